// File: doc/BRIEF.md
# PLL Divider Configuration Register Bank

This block is the software-visible configuration store for a clock synthesizer. It holds one control word, which takes effect the moment it is written, and four divider and modulation words that take effect only under a two-step protocol. Each of those four words has a staging copy and an active copy. A normal write changes only the staging copy. The active copy, which drives the divider outputs, is replaced only by a write that sets the word's own request bit. Software writes the value, then writes the same value again with the request bit set, and the divider receives every field of the word in one clock edge.

Access is through a simple word-addressed port: write enable, read enable, address and data. Read data is registered. One read-only status word reports the lock indication of the synthesizer. All active fields leave the block as registered, decoded outputs. The analog loop, power sequencing and waiting for lock are handled elsewhere.

Top module: `pll_cfg_regbank`

## Requirements
- R1: Synchronous active-high reset clears the control word, every staging and active copy, and the read data to zero.
- R2: The control word is at word address 0. A write updates the control outputs on the next edge: resistor bandwidth select from bits 3:0, integral select from 9:4, proportional select from 14:10, loop bypass from 15, feedback halving bypass from 16, fractional mode from 17, manual bandwidth from 18, pre-divider bypass from 19 and post-divider bypass from 20. Bits 20:0 read back, and higher bits read as zero.
- R3: A write to addresses 1 to 4 with that word's request bit clear changes only the staging copy. The active outputs keep their values.
- R4: A write to addresses 1 to 4 with the request bit set stores the written fields in both the staging and the active copy at the same edge. The active outputs show the new value in the cycle after the write.
- R5: Address 1 holds the pre-divider code in bits 9:0, with its request bit at 10. Address 2 holds the post-divider code in bits 6:0, with its request bit at 7.
- R6: Address 3 holds a 17-bit multiplier code in bits 16:0, with its request bit at 17. Bit 18 of the same word is the multiplier source select.
- R7: Address 4 holds the fractional multiplier in bits 10:0 and the integer multiplier in 18:11, with its request bit at 19. It also holds the modulation rate in 22:20, depth in 25:23, compensation in 27:26, modulator power-down in 28 and dither enable in 29.
- R8: Read data appears in the cycle after a read request and holds while no read is requested. Addresses 1 to 4 return the staging copy with the request bit read as zero and undefined bits read as zero.
- R9: Address 5 is read-only status. Bit 0 returns the lock input as sampled at the read edge, and writes to address 5 change nothing.
- R10: Writes to addresses 6 and 7 change nothing, and reads from them return zero.
- R11: A read and a write to the same address in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| lock_i | input | 1 | Lock indication from the synthesizer |
| bw_r | output | 4 | Resistor bandwidth select |
| bw_i | output | 6 | Integral bandwidth select |
| bw_p | output | 5 | Proportional bandwidth select |
| loop_bypass | output | 1 | Whole-loop bypass |
| fbhalf_bypass | output | 1 | Feedback halving bypass |
| frac_mode | output | 1 | Fractional / spread mode enable |
| manual_bw | output | 1 | Manual bandwidth and multiplier-code control |
| prediv_bypass | output | 1 | Pre-divider bypass |
| postdiv_bypass | output | 1 | Post-divider bypass |
| prediv_code | output | 10 | Active pre-divider code |
| postdiv_code | output | 7 | Active post-divider code |
| mult_code | output | 17 | Active multiplier code |
| mult_src_sel | output | 1 | Active multiplier source select |
| frac_mult | output | 11 | Active fractional multiplier |
| int_mult | output | 8 | Active integer multiplier |
| mod_rate | output | 3 | Active modulation rate |
| mod_depth | output | 3 | Active modulation depth |
| mod_comp | output | 2 | Active modulation compensation |
| mod_pd | output | 1 | Active modulator power-down |
| dither_en | output | 1 | Active dither enable |

## Verification
A read and a request-carrying write can address the same divider word in one cycle. The read returns the staging value as it stood before the edge, and the active output moves at that same edge. The bench raises both strobes together on the pre-divider word, then checks the returned data against the old staged value and the active code against the new one. Plain writes and latching writes are then interleaved on each word, so the staging readback and the active outputs are seen to diverge and later meet again.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  // word addresses
  localparam int A_CTRL = 0;
  localparam int A_PRE  = 1;
  localparam int A_POST = 2;
  localparam int A_SSA  = 3;
  localparam int A_SSB  = 4;
  localparam int A_STAT = 5;

  // field widths
  localparam int CTRL_W  = 21;
  localparam int PRE_W   = 10;
  localparam int POST_W  = 7;
  localparam int MCODE_W = 17;
  localparam int FRAC_W  = 11;
  localparam int INT_W   = 8;

  // staged words: request bit removed, fields packed low
  localparam int NSTG = 4;
  localparam int STG_W = 29;
  localparam int REQ_BIT [NSTG] = '{10, 7, 17, 19};
endpackage

// File: rtl/pcr_stage_latch.sv
module pcr_stage_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         req,
  input  logic [W-1:0] d,
  output logic [W-1:0] staged_q,
  output logic [W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      staged_q <= '0;
      active_q <= '0;
    end else if (load) begin
      staged_q <= d;
      if (req) active_q <= d;
    end
  end

  AST_PLAIN_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(load && req) |=> $stable(active_q)); // R3
  AST_REQ_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && req) |=> (active_q == $past(d) && staged_q == $past(d))); // R4
endmodule

// File: rtl/pcr_read_mux.sv
module pcr_read_mux
  import pcr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [CTRL_W-1:0]            ctrl_q,
  input  logic [NSTG-1:0][STG_W-1:0]   stg_q,
  input  logic                         lock_i,
  output logic [DATA_W-1:0]            word
);
  always_comb begin
    word = '0;
    case (addr)
      ADDR_W'(A_CTRL): word[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(A_PRE):  word[PRE_W-1:0]  = stg_q[0][PRE_W-1:0];
      ADDR_W'(A_POST): word[POST_W-1:0] = stg_q[1][POST_W-1:0];
      ADDR_W'(A_SSA): begin
        word[MCODE_W-1:0] = stg_q[2][MCODE_W-1:0];
        word[18]          = stg_q[2][MCODE_W];
      end
      ADDR_W'(A_SSB): begin
        word[18:0]  = stg_q[3][18:0];
        word[29:20] = stg_q[3][28:19];
      end
      ADDR_W'(A_STAT): word[0] = lock_i;
      default: word = '0;
    endcase
  end

  logic unused_stg;
  assign unused_stg = ^{stg_q[0][STG_W-1:PRE_W], stg_q[1][STG_W-1:POST_W],
                        stg_q[2][STG_W-1:MCODE_W+1]};
endmodule

// File: rtl/pll_cfg_regbank.sv
module pll_cfg_regbank
  import pcr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              lock_i,
  output logic [3:0]        bw_r,
  output logic [5:0]        bw_i,
  output logic [4:0]        bw_p,
  output logic              loop_bypass,
  output logic              fbhalf_bypass,
  output logic              frac_mode,
  output logic              manual_bw,
  output logic              prediv_bypass,
  output logic              postdiv_bypass,
  output logic [PRE_W-1:0]  prediv_code,
  output logic [POST_W-1:0] postdiv_code,
  output logic [MCODE_W-1:0] mult_code,
  output logic              mult_src_sel,
  output logic [FRAC_W-1:0] frac_mult,
  output logic [INT_W-1:0]  int_mult,
  output logic [2:0]        mod_rate,
  output logic [2:0]        mod_depth,
  output logic [1:0]        mod_comp,
  output logic              mod_pd,
  output logic              dither_en
);
  // ---------------- control word: takes effect directly
  logic [CTRL_W-1:0] ctrl_q;
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == ADDR_W'(A_CTRL));

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0];
  end

  assign bw_r           = ctrl_q[3:0];
  assign bw_i           = ctrl_q[9:4];
  assign bw_p           = ctrl_q[14:10];
  assign loop_bypass    = ctrl_q[15];
  assign fbhalf_bypass  = ctrl_q[16];
  assign frac_mode      = ctrl_q[17];
  assign manual_bw      = ctrl_q[18];
  assign prediv_bypass  = ctrl_q[19];
  assign postdiv_bypass = ctrl_q[20];

  // ---------------- staged / active words
  logic [NSTG-1:0][STG_W-1:0] stg_d, stg_q, act_q;
  logic [NSTG-1:0]            stg_sel, stg_req;

  always_comb begin
    stg_d    = '0;
    stg_d[0][PRE_W-1:0]   = wdata[PRE_W-1:0];
    stg_d[1][POST_W-1:0]  = wdata[POST_W-1:0];
    stg_d[2][MCODE_W-1:0] = wdata[MCODE_W-1:0];
    stg_d[2][MCODE_W]     = wdata[18];
    stg_d[3][18:0]        = wdata[18:0];
    stg_d[3][28:19]       = wdata[29:20];
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    assign stg_sel[g] = wr_en && (addr == ADDR_W'(g + 1));
    assign stg_req[g] = wdata[REQ_BIT[g]];
    pcr_stage_latch #(.W(STG_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .load     (stg_sel[g]),
      .req      (stg_req[g]),
      .d        (stg_d[g]),
      .staged_q (stg_q[g]),
      .active_q (act_q[g])
    );
  end

  assign prediv_code  = act_q[0][PRE_W-1:0];
  assign postdiv_code = act_q[1][POST_W-1:0];
  assign mult_code    = act_q[2][MCODE_W-1:0];
  assign mult_src_sel = act_q[2][MCODE_W];
  assign frac_mult    = act_q[3][FRAC_W-1:0];
  assign int_mult     = act_q[3][18:11];
  assign mod_rate     = act_q[3][21:19];
  assign mod_depth    = act_q[3][24:22];
  assign mod_comp     = act_q[3][26:25];
  assign mod_pd       = act_q[3][27];
  assign dither_en    = act_q[3][28];

  // ---------------- registered read port
  logic [DATA_W-1:0] rd_word;

  pcr_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmux (
    .addr   (addr),
    .ctrl_q (ctrl_q),
    .stg_q  (stg_q),
    .lock_i (lock_i),
    .word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  logic unused_bits;
  assign unused_bits = ^{wdata[DATA_W-1:30], act_q[0][STG_W-1:PRE_W],
                         act_q[1][STG_W-1:POST_W], act_q[2][STG_W-1:MCODE_W+1]};

  // ---------------- assertions
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable({postdiv_bypass, prediv_bypass, bw_p, bw_i, bw_r})); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R8
  AST_RD_STATUS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_STAT)) |=> (rdata == DATA_W'($past(lock_i)))); // R9
  AST_RD_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > ADDR_W'(A_STAT)) |=> (rdata == '0)); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata[DATA_W-1:30] == '0)); // R8
endmodule

// File: tb/test_pll_cfg_regbank.sv
`timescale 1ns/1ps
module test_pll_cfg_regbank;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lock_i = 0;
  logic [3:0]  bw_r; logic [5:0] bw_i; logic [4:0] bw_p;
  logic loop_bypass, fbhalf_bypass, frac_mode, manual_bw, prediv_bypass, postdiv_bypass;
  logic [9:0]  prediv_code; logic [6:0] postdiv_code; logic [16:0] mult_code;
  logic mult_src_sel; logic [10:0] frac_mult; logic [7:0] int_mult;
  logic [2:0] mod_rate, mod_depth; logic [1:0] mod_comp; logic mod_pd, dither_en;

  always #5 clk = ~clk;

  pll_cfg_regbank i_pll_cfg_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lock_i(lock_i), .bw_r(bw_r), .bw_i(bw_i), .bw_p(bw_p),
    .loop_bypass(loop_bypass), .fbhalf_bypass(fbhalf_bypass), .frac_mode(frac_mode),
    .manual_bw(manual_bw), .prediv_bypass(prediv_bypass), .postdiv_bypass(postdiv_bypass),
    .prediv_code(prediv_code), .postdiv_code(postdiv_code), .mult_code(mult_code),
    .mult_src_sel(mult_src_sel), .frac_mult(frac_mult), .int_mult(int_mult),
    .mod_rate(mod_rate), .mod_depth(mod_depth), .mod_comp(mod_comp), .mod_pd(mod_pd),
    .dither_en(dither_en));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // model: index 0 = control word, 1..4 = staged words
  logic [31:0] stg [0:4];
  logic [31:0] act [1:4];
  localparam logic [31:0] MASK [0:4] = '{32'h001F_FFFF, 32'h0000_03FF, 32'h0000_007F,
                                          32'h0005_FFFF, 32'h3FF7_FFFF};
  localparam int REQ [1:4] = '{10, 7, 17, 19};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] act_word(input int i);
    case (i)
      0: act_word = {11'b0, postdiv_bypass, prediv_bypass, manual_bw, frac_mode,
                     fbhalf_bypass, loop_bypass, bw_p, bw_i, bw_r};
      1: act_word = {22'b0, prediv_code};
      2: act_word = {25'b0, postdiv_code};
      3: act_word = {13'b0, mult_src_sel, 1'b0, mult_code};
      default: act_word = {2'b0, dither_en, mod_pd, mod_comp, mod_depth, mod_rate,
                           1'b0, int_mult, frac_mult};
    endcase
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a == 0) stg[0] = d & MASK[0];
    else if (a >= 1 && a <= 4) begin
      stg[a] = d & MASK[a];
      if (d[REQ[a]]) act[a] = stg[a];
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_write(input int a, input logic [31:0] d);
    wr_en = 1; addr = 3'(a); wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    model_write(a, d);
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    rd_en = 1; addr = 3'(a);
    @(posedge clk); @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      bus_read(i, d);
      check($sformatf("%s readback addr %0d", tag, i), d, stg[i]);
      if (i == 0) check($sformatf("%s control outputs", tag), act_word(0), stg[0]);
      else check($sformatf("%s active addr %0d", tag, i), act_word(i), act[i]);
    end
  endtask

  task automatic t_reset;
    check("R1 rdata after reset", rdata, 32'h0);
    check_all("R1 reset");
  endtask

  task automatic t_ctrl;
    bus_write(0, 32'hFFFF_FFFF);
    check("R2 control all ones", act_word(0), 32'h001F_FFFF);
    bus_write(0, 32'h000A_5A5A);
    check("R2 integral select field", {26'b0, bw_i}, (32'h000A_5A5A >> 4) & 32'h3F);
    check("R2 post bypass bit 20", {31'b0, postdiv_bypass}, 32'h0);
    check("R2 manual bandwidth bit 18", {31'b0, manual_bw}, 32'h0);
    check("R2 fractional bit 17", {31'b0, frac_mode}, 32'h1);
    check_all("R2 control");
  endtask

  task automatic t_stage_latch;
    logic [31:0] v [1:4] = '{32'h0000_0155, 32'h0000_0036, 32'h0004_A5C3, 32'h2A56_3A17};
    for (int i = 1; i < 5; i++) begin
      bus_write(i, v[i]);
      check($sformatf("R3 plain write keeps active addr %0d", i), act_word(i), act[i]);
      bus_write(i, v[i] | (32'h1 << REQ[i]));
      check($sformatf("R4 request write loads addr %0d", i), act_word(i), v[i] & MASK[i]);
    end
    check("R5 pre-divider code", {22'b0, prediv_code}, 32'h155);
    check("R5 post-divider code", {25'b0, postdiv_code}, 32'h36);
    check("R6 multiplier code", {15'b0, mult_code}, 32'h0A5C3);
    check("R6 source select bit 18", {31'b0, mult_src_sel}, 32'h1);
    check("R7 integer multiplier", {24'b0, int_mult}, (32'h2A56_3A17 >> 11) & 32'hFF);
    check("R7 modulation depth", {29'b0, mod_depth}, (32'h2A56_3A17 >> 23) & 32'h7);
    check("R7 dither bit 29", {31'b0, dither_en}, 32'h1);
    check_all("R8 request bit reads zero");
  endtask

  task automatic t_direct_and_all_ones;
    for (int i = 1; i < 5; i++) bus_write(i, 32'hFFFF_FFFF);
    check_all("R4 single request write");
    for (int i = 1; i < 5; i++) bus_write(i, 32'h0);
    check_all("R3 zero staged while active ones");
  endtask

  task automatic t_undef;
    logic [31:0] d;
    bus_write(6, 32'hFFFF_FFFF);
    bus_write(7, 32'hFFFF_FFFF);
    bus_write(5, 32'hFFFF_FFFF);
    check_all("R10 R9 ignored writes");
    bus_read(6, d); check("R10 read addr 6", d, 32'h0);
    bus_read(7, d); check("R10 read addr 7", d, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    lock_i = 1; bus_read(5, d); check("R9 lock high", d, 32'h1);
    lock_i = 0; bus_read(5, d); check("R9 lock low", d, 32'h0);
  endtask

  task automatic t_rd_hold;
    logic [31:0] d;
    bus_read(3, d);
    bus_write(3, 32'h0002_1234);
    check("R8 rdata holds without read", rdata, d);
  endtask

  task automatic t_same_cycle;
    logic [31:0] old;
    old = stg[1];
    rd_en = 1; wr_en = 1; addr = 3'd1; wdata = 32'h0000_0777;
    @(posedge clk); @(negedge clk);
    rd_en = 0; wr_en = 0;
    check("R11 read returns pre-write value", rdata, old);
    model_write(1, 32'h0000_0777);
    check("R11 active updated same edge", act_word(1), 32'h0000_0377);
    check_all("R11 after collision");
  endtask

  initial begin
    for (int i = 0; i < 5; i++) stg[i] = '0;
    for (int i = 1; i < 5; i++) act[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_ctrl();
    t_stage_latch();
    t_direct_and_all_ones();
    t_undef();
    t_status();
    t_rd_hold();
    t_same_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule